// File: doc/BRIEF.md
# Flash Program and Erase Sequencer with Status Word

This block is the self-timed engine inside one byte lane of a flash array. A command decoder upstream turns bus write sequences into single-cycle start pulses: program one byte, erase selected sectors, erase the whole lane, or reset. The engine then times the operation in clock cycles, drives a simple synchronous write port into the array, and, while it runs, substitutes a status byte for array data on the read path. Host software polls this byte to follow progress.

A sector-erase request opens a collection window. Further sector-erase requests that arrive before the window runs out add their sector and restart the window. Any other command in the window cancels the request. When the window closes, every byte of each selected, unprotected sector is first cleared to 00h and then set to FFh. Protected sectors are never written. A program request that would raise a 0 bit to 1 fails: the lane stays in status mode with the failure flag set until a reset command arrives. A request that touches only protected storage shows busy status for a fixed time and then does nothing. All durations are parameters in clock cycles.

Top module: `flash_pe_engine`

## Requirements
- R1: After reset, `busy` is 0 and `rd_data` shows the array byte at `rd_addr` (combinational array read). The internal toggle flag starts at 0.
- R2: A program request writes `cmd_data` at `cmd_addr` after PROG_CYC cycles. While it runs, status bit 7 is the inverse of bit 7 of `cmd_data`. Once it ends, reads return array data.
- R3: In status mode, `rd_data` is {bit7 poll, bit6 toggle, bit5 fail, 0, bit3 erase-started, 0, 0, 0}. The toggle bit inverts after every `rd_stb` taken in status mode, at any address.
- R4: If the program data has a 1 where the stored byte has a 0, the array is left unchanged. The engine then enters a fail state: status bit 5 = 1, bit 7 = inverse of data bit 7, `busy` = 0. It leaves this state only on `go_reset` and ignores the other commands.
- R5: Programming into a protected sector writes nothing. It shows status with `busy` high for exactly PPROG_CYC cycles, then returns to array reads.
- R6: A sector-erase request opens a window of WIN_CYC cycles with status bits 7 and 3 at 0. Each further sector-erase request in the window adds its sector and restarts the window.
- R7: A program, chip-erase or reset command during the window cancels the erase. The array is left unchanged and the cancelling command is not executed.
- R8: Erase writes 00h to every byte of the selected unprotected sectors, then FFh to each of them, walking the addresses upward, ERASE_CYC cycles per byte. Status bit 3 = 1 and bit 7 = 0 throughout. Unselected sectors are untouched.
- R9: Protected sectors are skipped by the erase. If every selected sector is protected, the engine shows erase status (bit 3 = 1) for PERASE_CYC cycles and writes nothing.
- R10: A chip-erase request skips the window and starts erasing every unprotected sector at once.
- R11: `busy` is high while programming, erasing or holding protected status. In that time `arr_we` is the only array writer, and every command, reset included, is ignored.
- R12: The sector of an address is its top SW bits. `prot_mask` bit n protects sector n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_prog | input | 1 | Start a byte program at `cmd_addr` with `cmd_data` |
| go_sect | input | 1 | Add the sector of `cmd_addr` to an erase |
| go_chip | input | 1 | Start an erase of all unprotected sectors |
| go_reset | input | 1 | Reset command from the decoder |
| cmd_addr | input | AW | Command address |
| cmd_data | input | 8 | Program data |
| prot_mask | input | 2**SW | Per-sector write protection |
| rd_addr | input | AW | Read address |
| rd_stb | input | 1 | One pulse per read cycle |
| rd_data | output | 8 | Array byte or status byte |
| busy | output | 1 | Operation in progress, commands ignored |
| arr_addr | output | AW | Array address |
| arr_we | output | 1 | Array write enable |
| arr_wdata | output | 8 | Array write data |
| arr_rdata | input | 8 | Array read data at `arr_addr`, combinational |

## Verification
The checks assume that `prot_mask` stays constant while an operation is pending or running. They also assume that the array returns the byte at `arr_addr` in the same cycle, and that at most one `go_*` pulse arrives per cycle. The stimulus changes protection only while the engine is idle and never holds `busy` high on a command. Its array model is a plain byte memory with a combinational read port. Every command pulse lasts one cycle, so these assumptions always hold.

// File: rtl/flash_pe_engine.sv
module flash_pe_engine #(
  parameter int AW         = 8,
  parameter int SW         = 2,
  parameter int PROG_CYC   = 40,
  parameter int ERASE_CYC  = 2,
  parameter int WIN_CYC    = 40,
  parameter int PPROG_CYC  = 12,
  parameter int PERASE_CYC = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go_prog,
  input  logic                go_sect,
  input  logic                go_chip,
  input  logic                go_reset,
  input  logic [AW-1:0]       cmd_addr,
  input  logic [7:0]          cmd_data,
  input  logic [(1<<SW)-1:0]  prot_mask,
  input  logic [AW-1:0]       rd_addr,
  input  logic                rd_stb,
  output logic [7:0]          rd_data,
  output logic                busy,
  output logic [AW-1:0]       arr_addr,
  output logic                arr_we,
  output logic [7:0]          arr_wdata,
  input  logic [7:0]          arr_rdata
);
  localparam int NSECT = 1 << SW;
  localparam int M1    = (PROG_CYC > WIN_CYC) ? PROG_CYC : WIN_CYC;
  localparam int M2    = (PPROG_CYC > PERASE_CYC) ? PPROG_CYC : PERASE_CYC;
  localparam int M3    = (M1 > M2) ? M1 : M2;
  localparam int MAXC  = (M3 > ERASE_CYC) ? M3 : ERASE_CYC;
  localparam int CW    = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_PROG = 3'd1, S_WIN = 3'd2,
    S_ERASE = 3'd3, S_PBUSY = 3'd4, S_FAIL = 3'd5
  } st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [AW-1:0]    pa, ea;
  logic [7:0]       pd;
  logic [NSECT-1:0] sel, cmd_bit, win_eff;
  logic             ephase, is_erase, tgl;
  logic             prog_bad, prog_end, pb_end, win_end, byte_end;
  logic             dq7, dq5, dq3;

  assign cmd_bit  = NSECT'(1) << cmd_addr[AW-1 -: SW];
  assign win_eff  = sel & ~prot_mask;
  assign prog_bad = |(~arr_rdata & pd);
  assign prog_end = cnt == CW'(PROG_CYC - 1);
  assign pb_end   = cnt == (is_erase ? CW'(PERASE_CYC - 1) : CW'(PPROG_CYC - 1));
  assign win_end  = cnt == CW'(WIN_CYC - 1);
  assign byte_end = cnt == CW'(ERASE_CYC - 1);

  assign arr_addr  = (st == S_PROG) ? pa : (st == S_ERASE) ? ea : rd_addr;
  assign arr_we    = (st == S_PROG && prog_end && !prog_bad) ||
                     (st == S_ERASE && byte_end && sel[ea[AW-1 -: SW]]);
  assign arr_wdata = (st == S_ERASE) ? {8{ephase}} : pd;

  assign dq7     = is_erase ? 1'b0 : ~pd[7];
  assign dq5     = st == S_FAIL;
  assign dq3     = (st == S_ERASE) || (st == S_PBUSY && is_erase);
  assign rd_data = (st == S_IDLE) ? arr_rdata : {dq7, tgl, dq5, 1'b0, dq3, 3'b000};
  assign busy    = (st == S_PROG) || (st == S_ERASE) || (st == S_PBUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  cnt <= '0;  pa <= '0;  pd <= '0;  sel <= '0;
      ea <= '0;  ephase <= 1'b0;  is_erase <= 1'b0;  tgl <= 1'b0;
    end else begin
      if (rd_stb && st != S_IDLE) tgl <= ~tgl;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          ea  <= '0;
          ephase <= 1'b0;
          if (go_prog) begin
            pa <= cmd_addr;
            pd <= cmd_data;
            is_erase <= 1'b0;
            st <= (|(cmd_bit & prot_mask)) ? S_PBUSY : S_PROG;
          end else if (go_chip) begin
            is_erase <= 1'b1;
            sel <= ~prot_mask;
            st  <= (&prot_mask) ? S_PBUSY : S_ERASE;
          end else if (go_sect) begin
            is_erase <= 1'b1;
            sel <= cmd_bit;
            st  <= S_WIN;
          end
        end
        S_PROG: begin
          cnt <= cnt + 1'b1;
          if (prog_end) st <= prog_bad ? S_FAIL : S_IDLE;
        end
        S_PBUSY: begin
          cnt <= cnt + 1'b1;
          if (pb_end) st <= S_IDLE;
        end
        S_WIN: begin
          if (go_sect) begin
            sel <= sel | cmd_bit;
            cnt <= '0;
          end else if (go_prog || go_chip || go_reset) begin
            st <= S_IDLE;
          end else if (win_end) begin
            cnt <= '0;
            sel <= win_eff;
            st  <= (win_eff == '0) ? S_PBUSY : S_ERASE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_ERASE: begin
          if (byte_end) begin
            cnt <= '0;
            ea  <= ea + 1'b1;
            if (&ea) begin
              if (ephase) st <= S_IDLE;
              else ephase <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_FAIL: if (go_reset) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module flash_pe_engine_chk #(
  parameter int CW      = 6,
  parameter int WIN_CYC = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    st,
  input logic [CW-1:0] cnt,
  input logic          tgl,
  input logic          pd7,
  input logic          rd_stb,
  input logic [7:0]    rd_data,
  input logic          go_reset,
  input logic          busy,
  input logic          arr_we
);
  localparam logic [2:0] C_IDLE = 3'd0, C_PROG = 3'd1, C_WIN = 3'd2,
                         C_ERASE = 3'd3, C_FAIL = 3'd5;

  // R2
  prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == C_PROG |-> rd_data[7] == ~pd7);
  // R3
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && st != C_IDLE) |=> tgl != $past(tgl));
  // R4
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_FAIL && !go_reset) |=> st == C_FAIL);
  // R4
  fail_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == C_FAIL |-> (rd_data[5] && !busy && !arr_we));
  // R6
  win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == C_WIN |-> (cnt < CW'(WIN_CYC) && !rd_data[3] && !rd_data[7]));
  // R8
  erase_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == C_ERASE |-> (rd_data[3] && !rd_data[7]));
  // R11
  write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
endmodule

bind flash_pe_engine flash_pe_engine_chk #(.CW(CW), .WIN_CYC(WIN_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .cnt(cnt), .tgl(tgl), .pd7(pd[7]),
  .rd_stb(rd_stb), .rd_data(rd_data), .go_reset(go_reset), .busy(busy),
  .arr_we(arr_we)
);

// File: tb/flash_pe_engine_bench.sv
module flash_pe_engine_bench;
  localparam int AW = 8, SW = 2;
  localparam int PROG_CYC = 40, WIN_CYC = 40, PPROG_CYC = 12, PERASE_CYC = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic go_prog = 0, go_sect = 0, go_chip = 0, go_reset = 0, rd_stb = 0;
  logic [AW-1:0] cmd_addr = '0, rd_addr = '0, arr_addr;
  logic [7:0] cmd_data = '0, rd_data, arr_wdata, arr_rdata;
  logic [3:0] prot_mask = '0;
  logic busy, arr_we;
  logic [7:0] mem [256];

  int checks = 0, errors = 0;
  logic tgl_m = 1'b0;
  logic saw_zero = 0, zero_then_ff = 0;
  logic done = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  flash_pe_engine #(.AW(AW), .SW(SW), .PROG_CYC(PROG_CYC), .ERASE_CYC(2),
    .WIN_CYC(WIN_CYC), .PPROG_CYC(PPROG_CYC), .PERASE_CYC(PERASE_CYC)) u_flash_pe_engine (
    .clk(clk), .rst_n(rst_n), .go_prog(go_prog), .go_sect(go_sect), .go_chip(go_chip),
    .go_reset(go_reset), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .prot_mask(prot_mask),
    .rd_addr(rd_addr), .rd_stb(rd_stb), .rd_data(rd_data), .busy(busy),
    .arr_addr(arr_addr), .arr_we(arr_we), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata));

  assign arr_rdata = mem[arr_addr];
  always @(posedge clk) if (arr_we) mem[arr_addr] <= arr_wdata;

  always @(negedge clk) begin
    #2;
    if (arr_we && arr_addr == 8'h10) begin
      if (arr_wdata == 8'h00) saw_zero = 1;
      if (arr_wdata == 8'hFF && saw_zero) zero_then_ff = 1;
    end
    if (rd_stb && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (rd_data !== it.exp) begin
        errors++;
        $display("FAIL %s: got %02h expected %02h", it.tag, rd_data, it.exp);
      end
    end
  end

  task automatic check(input logic ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    q.push_back(it);
    @(negedge clk); rd_addr = a; rd_stb = 1;
    @(negedge clk); rd_stb = 0;
  endtask

  task automatic srd(input logic [7:0] a, input logic [7:0] bits, input string tag);
    logic [7:0] e;
    e = bits | {1'b0, tgl_m, 6'b0};
    tgl_m = ~tgl_m;
    rd(a, e, tag);
  endtask

  task automatic cmd(input int kind, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_addr = a; cmd_data = d;
    go_prog = (kind == 0); go_chip = (kind == 1); go_sect = (kind == 2); go_reset = (kind == 3);
    @(negedge clk);
    go_prog = 0; go_chip = 0; go_sect = 0; go_reset = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    mem[8'hC4] = 8'h12;
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    check(busy == 0, "R1 busy after reset", busy, 0);
    rd(8'hC4, 8'h12, "R1 array read after reset");

    // R2 program, R3 toggle, R11 commands ignored while busy
    cmd(0, 8'h10, 8'h5A);
    srd(8'h33, 8'h80, "R2 poll bit inverted");
    srd(8'h10, 8'h80, "R3 toggle second read");
    check(busy == 1, "R11 busy during program", busy, 1);
    cmd(1, 8'h00, 8'h00);
    cmd(3, 8'h00, 8'h00);
    srd(8'h10, 8'h80, "R11 reset ignored while busy");
    wait_idle();
    rd(8'h10, 8'h5A, "R2 programmed byte");
    rd(8'h20, 8'hFF, "R11 chip erase ignored");
    cmd(0, 8'h11, 8'hA5);
    srd(8'h11, 8'h00, "R2 poll bit for data bit7=1");
    wait_idle();
    rd(8'h11, 8'hA5, "R2 second programmed byte");
    cmd(0, 8'h50, 8'h00); wait_idle();
    cmd(0, 8'h90, 8'h33); wait_idle();

    // R4 raising a 0 bit fails
    cmd(0, 8'h10, 8'hFF);
    idle(PROG_CYC + 3);
    check(busy == 0, "R4 busy low in fail", busy, 0);
    srd(8'h10, 8'h20, "R4 fail status");
    cmd(0, 8'h20, 8'h00);
    srd(8'h10, 8'h20, "R4 fail holds over program command");
    cmd(3, 8'h00, 8'h00);
    rd(8'h10, 8'h5A, "R4 array unchanged after fail");
    rd(8'h20, 8'hFF, "R4 command in fail not executed");

    // R5 protected program, R12 sector = top bits
    prot_mask = 4'b1000;
    cmd(0, 8'hC4, 8'h00);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(n == PPROG_CYC, "R5 protected busy length", n, PPROG_CYC);
    rd(8'hC4, 8'h12, "R5 R12 protected byte unchanged");

    // R6 window restart, R8 erase order and scope
    cmd(2, 8'h05, 8'h00);
    srd(8'h05, 8'h00, "R6 window status");
    idle(28);
    cmd(2, 8'h47, 8'h00);
    idle(30);
    srd(8'h05, 8'h00, "R6 window restarted");
    check(busy == 0, "R6 not busy in window", busy, 0);
    idle(WIN_CYC);
    srd(8'h05, 8'h08, "R8 erase started status");
    wait_idle();
    rd(8'h10, 8'hFF, "R8 sector0 erased");
    rd(8'h50, 8'hFF, "R6 added sector1 erased");
    rd(8'h90, 8'h33, "R8 unselected sector kept");
    check(zero_then_ff == 1, "R8 zero pass before ones", zero_then_ff, 1);

    // R7 abort in window
    cmd(2, 8'h90, 8'h00);
    srd(8'h90, 8'h00, "R7 window open");
    cmd(0, 8'h91, 8'h00);
    check(busy == 0, "R7 idle after abort", busy, 0);
    rd(8'h91, 8'hFF, "R7 cancelling program not run");
    idle(WIN_CYC + 10);
    rd(8'h90, 8'h33, "R7 erase cancelled");

    // R9 all selected sectors protected
    cmd(2, 8'hC0, 8'h00);
    idle(WIN_CYC + 2);
    srd(8'hC0, 8'h08, "R9 protected erase status");
    check(busy == 1, "R9 busy while protected erase", busy, 1);
    wait_idle();
    rd(8'hC4, 8'h12, "R9 protected sector kept");

    // R10 chip erase without window
    cmd(1, 8'h00, 8'h00);
    srd(8'h00, 8'h08, "R10 erase starts at once");
    wait_idle();
    rd(8'h90, 8'hFF, "R10 sector2 erased");
    rd(8'hC4, 8'h12, "R10 R9 protected sector skipped");

    idle(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule